// File: doc/BRIEF.md
# I2C Slave Line Conditioner and Bus Condition Detector

This block sits between the raw SCL and SDA pins of an I2C slave and the slave's byte logic, all clocked from a fast system clock. Each line passes through a synchronizer and then a spike filter. The filter adopts a new level only after that level has stayed put for longer than a programmable number of clock samples. The cleaned lines feed a detector that reports start and stop conditions and the rising edges of SCL, where the byte logic samples a data bit.

The slave may be the transmitter. It must then not move SDA too soon after SCL falls, or a watching device could read the change as a start or a stop. A hold timer therefore issues a permission strobe only after the cleaned SCL has been low for a programmable number of cycles. An idle tracker raises a level once both lines have been high for a programmable bus-free interval.

Cleaned levels lag the pins by `SYNC_STAGES + SPIKE_CYC` cycles. Every output is registered one cycle after that. At 250 MHz the defaults give a rejected-spike limit of 52 ns, a 300 ns output hold and a 1.3 us bus-free time.

Top module: `i2c_bus_frontend`

## Requirements
- R1: While `rst` is high, `start_det`, `stop_det`, `scl_rise`, `sda_drive_ok` and `bus_idle` are all 0, and the cleaned levels of both lines are held at 1.
- R2: For each line, the cleaned level after clock edge n takes value v only if the raw pin was v at all of the edges n-SYNC_STAGES-SPIKE_CYC through n-SYNC_STAGES; otherwise it keeps its previous value. A pulse of at most SPIKE_CYC samples never changes it, and a pulse of SPIKE_CYC+1 samples always does.
- R3: `start_det` is 1 for the single cycle after edge n exactly when the cleaned SCL was 1 after both edge n-2 and edge n-1, and the cleaned SDA went from 1 (after n-2) to 0 (after n-1).
- R4: `stop_det` is 1 for the single cycle after edge n exactly when the cleaned SCL was 1 after both edge n-2 and edge n-1, and the cleaned SDA went from 0 to 1 over those two edges.
- R5: `scl_rise` is 1 for the single cycle after edge n exactly when the cleaned SCL was 0 after edge n-2 and 1 after edge n-1.
- R6: `sda_drive_ok` is 1 for the single cycle after edge n exactly when the cleaned SCL was 1 after edge n-HOLD_CYC-1 and 0 after each of the edges n-HOLD_CYC through n-1. If SCL goes high before HOLD_CYC low cycles have passed, no strobe is issued for that low phase.
- R7: `bus_idle` is 1 after edge n exactly when both cleaned lines were 1 after each of the edges n-FREE_CYC through n-1. Before reset release, both lines count as having been high. It drops one cycle after either cleaned line goes low.
- R8: If the cleaned SCL and SDA change in the same cycle, neither `start_det` nor `stop_det` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| start_det | output | 1 | One-cycle pulse: start condition seen |
| stop_det | output | 1 | One-cycle pulse: stop condition seen |
| scl_rise | output | 1 | One-cycle pulse: sample the data bit now |
| sda_drive_ok | output | 1 | One-cycle pulse: output hold after SCL fall has elapsed |
| bus_idle | output | 1 | Both lines high for at least the bus-free time |

## Verification
The hardest states to reach are the exact filter boundaries. A pulse of exactly SPIKE_CYC samples must vanish, and one of SPIKE_CYC+1 samples must pass. A low phase of HOLD_CYC-1 cycles must yield no drive strobe, while one of exactly HOLD_CYC cycles must yield one. Both lines changing on the same edge must produce neither condition. Directed segments with those exact lengths reach each of these boundaries. Seeded random segments then add runs that are mostly near the spike length or the hold length, plus occasional runs past the bus-free time. A per-cycle reference model built from the window rules above checks every output on every cycle.

// File: rtl/i2c_fe_pkg.sv
package i2c_fe_pkg;
  localparam int NUM_LINES = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;
endpackage

// File: rtl/i2c_fe_sync.sv
module i2c_fe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_fe_spike_filter.sv
module i2c_fe_spike_filter #(
  parameter int SPIKE_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(SPIKE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= 1'b1;
      cnt  <= '0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (cnt == CW'(SPIKE_CYC)) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2: a level change needs a full run of differing samples
  assert_full_run_R2: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> ($past(cnt) == CW'(SPIKE_CYC)));
  // R2: the cleaned level only moves toward the synchronized input
  assert_follows_input_R2: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> (dout == $past(din)));
endmodule

// File: rtl/i2c_fe_cond_detect.sv
module i2c_fe_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
      scl_rise  <= 1'b0;
    end else begin
      scl_q     <= scl;
      sda_q     <= sda;
      start_det <= scl & scl_q & sda_q & ~sda;
      stop_det  <= scl & scl_q & ~sda_q & sda;
      scl_rise  <= scl & ~scl_q;
    end
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !start_det);
  assert_stop_single_R4: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !stop_det);
  assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
    scl_rise |=> !scl_rise);
endmodule

// File: rtl/i2c_fe_hold_timer.sv
module i2c_fe_hold_timer #(
  parameter int HOLD_CYC = 75
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  output logic drive_ok
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  logic [HW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      drive_ok <= 1'b0;
    end else begin
      drive_ok <= !scl && (low_run == HW'(HOLD_CYC - 1));
      if (scl)                          low_run <= '0;
      else if (low_run != HW'(HOLD_CYC)) low_run <= low_run + 1'b1;
    end
  end

  assert_no_drive_after_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(scl) |=> !drive_ok);
  assert_drive_single_R6: assert property (@(posedge clk) disable iff (rst)
    drive_ok |=> !drive_ok);
endmodule

// File: rtl/i2c_fe_idle_timer.sv
module i2c_fe_idle_timer #(
  parameter int FREE_CYC = 325
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic idle
);
  localparam int FW = $clog2(FREE_CYC + 1);
  logic [FW-1:0] run;
  logic          both_high;

  assign both_high = scl & sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= FW'(FREE_CYC);
      idle <= 1'b0;
    end else begin
      idle <= both_high && (run >= FW'(FREE_CYC - 1));
      if (!both_high)                run <= '0;
      else if (run != FW'(FREE_CYC)) run <= run + 1'b1;
    end
  end

  assert_idle_drop_scl_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(scl) |=> !idle);
  assert_idle_drop_sda_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(sda) |=> !idle);
endmodule

// File: rtl/i2c_bus_frontend.sv
module i2c_bus_frontend
  import i2c_fe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SPIKE_CYC   = 13,
  parameter int HOLD_CYC    = 75,
  parameter int FREE_CYC    = 325
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic sda_drive_ok,
  output logic bus_idle
);
  logic [NUM_LINES-1:0] raw, synced, clean;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    i2c_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst (rst), .d (raw[i]), .q (synced[i])
    );
    i2c_fe_spike_filter #(.SPIKE_CYC(SPIKE_CYC)) u_filt (
      .clk (clk), .rst (rst), .din (synced[i]), .dout (clean[i])
    );
  end

  i2c_fe_cond_detect u_det (
    .clk (clk), .rst (rst),
    .scl (clean[LINE_SCL]), .sda (clean[LINE_SDA]),
    .start_det (start_det), .stop_det (stop_det), .scl_rise (scl_rise)
  );

  i2c_fe_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk (clk), .rst (rst), .scl (clean[LINE_SCL]), .drive_ok (sda_drive_ok)
  );

  i2c_fe_idle_timer #(.FREE_CYC(FREE_CYC)) u_idle (
    .clk (clk), .rst (rst),
    .scl (clean[LINE_SCL]), .sda (clean[LINE_SDA]), .idle (bus_idle)
  );

  // R8: no condition may be reported while both lines move together
  assert_no_cond_on_joint_move_R8: assert property (@(posedge clk) disable iff (rst)
    ((clean[LINE_SCL] != $past(clean[LINE_SCL])) && (clean[LINE_SDA] != $past(clean[LINE_SDA])))
    |=> !(start_det || stop_det));
endmodule

// File: tb/i2c_bus_frontend_tb.sv
module i2c_bus_frontend_tb;
  localparam int SYNC  = 2;
  localparam int SPIKE = 13;
  localparam int HOLD  = 75;
  localparam int FREE  = 325;
  localparam int NMAX  = 120000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_i = 1'b1, sda_i = 1'b1;
  logic start_det, stop_det, scl_rise, sda_drive_ok, bus_idle;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int seen_start = 0, seen_stop = 0, seen_rise = 0, seen_drv = 0;
  bit raw_c [NMAX];
  bit raw_d [NMAX];
  bit mf_c  [NMAX];
  bit mf_d  [NMAX];

  always #2 clk = ~clk;

  i2c_bus_frontend #(.SYNC_STAGES(SYNC), .SPIKE_CYC(SPIKE), .HOLD_CYC(HOLD), .FREE_CYC(FREE)) u_dut (
    .clk (clk), .rst (rst), .scl_i (scl_i), .sda_i (sda_i),
    .start_det (start_det), .stop_det (stop_det), .scl_rise (scl_rise),
    .sda_drive_ok (sda_drive_ok), .bus_idle (bus_idle)
  );

  function automatic bit rc(int k); return (k < 0) ? 1'b1 : raw_c[k]; endfunction
  function automatic bit rd(int k); return (k < 0) ? 1'b1 : raw_d[k]; endfunction
  function automatic bit fc(int k); return (k < 0) ? 1'b1 : mf_c[k];  endfunction
  function automatic bit fd(int k); return (k < 0) ? 1'b1 : mf_d[k];  endfunction

  // R2 window rule for the cleaned levels after edge n
  function automatic void model_filter(int n);
    bit vc = rc(n - SYNC), vd = rd(n - SYNC);
    bit okc = 1'b1, okd = 1'b1;
    for (int k = n - SYNC - SPIKE; k <= n - SYNC; k++) begin
      if (rc(k) != vc) okc = 1'b0;
      if (rd(k) != vd) okd = 1'b0;
    end
    mf_c[n] = okc ? vc : fc(n - 1);
    mf_d[n] = okd ? vd : fd(n - 1);
  endfunction

  function automatic bit exp_start(int n);
    return fc(n-1) & fc(n-2) & fd(n-2) & ~fd(n-1);
  endfunction
  function automatic bit exp_stop(int n);
    return fc(n-1) & fc(n-2) & ~fd(n-2) & fd(n-1);
  endfunction
  function automatic bit exp_rise(int n);
    return fc(n-1) & ~fc(n-2);
  endfunction
  function automatic bit exp_drive(int n);
    bit r = fc(n - HOLD - 1);
    for (int k = n - HOLD; k <= n - 1; k++) if (fc(k)) r = 1'b0;
    return r;
  endfunction
  function automatic bit exp_idle(int n);
    bit r = 1'b1;
    for (int k = n - FREE; k <= n - 1; k++) if (!(fc(k) && fd(k))) r = 1'b0;
    return r;
  endfunction

  task automatic chk(input bit act, input bit exp, input string req, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d act %0b exp %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input bit c, input bit d);
    scl_i = c;
    sda_i = d;
    if (cyc < NMAX) begin
      raw_c[cyc] = c;
      raw_d[cyc] = d;
      model_filter(cyc);
    end
    @(negedge clk);
    if (cyc < NMAX) begin
      chk(start_det,    exp_start(cyc), "R3", "start_det");
      chk(stop_det,     exp_stop(cyc),  "R4", "stop_det");
      chk(scl_rise,     exp_rise(cyc),  "R5", "scl_rise");
      chk(sda_drive_ok, exp_drive(cyc), "R6", "sda_drive_ok");
      chk(bus_idle,     exp_idle(cyc),  "R7", "bus_idle");
    end
    seen_start += int'(start_det);
    seen_stop  += int'(stop_det);
    seen_rise  += int'(scl_rise);
    seen_drv   += int'(sda_drive_ok);
    cyc++;
  endtask

  task automatic hold_for(input bit c, input bit d, input int len);
    for (int i = 0; i < len; i++) tick(c, d);
  endtask

  task automatic clear_seen();
    seen_start = 0; seen_stop = 0; seen_rise = 0; seen_drv = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h1bad5eed);
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(start_det, 1'b0, "R1", "start_det in reset");
    chk(stop_det, 1'b0, "R1", "stop_det in reset");
    chk(scl_rise, 1'b0, "R1", "scl_rise in reset");
    chk(sda_drive_ok, 1'b0, "R1", "sda_drive_ok in reset");
    chk(bus_idle, 1'b0, "R1", "bus_idle in reset");
    rst = 1'b0;

    hold_for(1, 1, FREE + 20);

    // R2: spikes of exactly SPIKE samples on either line are rejected
    clear_seen();
    for (int i = 0; i < 4; i++) begin
      hold_for(1, 0, SPIKE); hold_for(1, 1, 25);
      hold_for(0, 1, SPIKE); hold_for(1, 1, 25);
    end
    chk_int(seen_start, 0, "R2", "start from SDA spikes");
    chk_int(seen_rise, 0, "R2", "SCL rise from spikes");

    // R2/R3: a low run of SPIKE+1 samples is taken as a start
    clear_seen();
    hold_for(1, 0, SPIKE + 1);
    hold_for(1, 1, 30);
    chk_int(seen_start, 1, "R2", "start from SPIKE+1 run");
    chk_int(seen_stop, 1, "R4", "stop after SPIKE+1 high run");

    // a start, then several bits with full low phases
    clear_seen();
    hold_for(1, 0, 40);
    for (int b = 0; b < 4; b++) begin
      hold_for(0, 0, 10);
      hold_for(0, b[0], HOLD + 20);
      hold_for(1, b[0], 40);
    end
    chk_int(seen_rise, 4, "R5", "bit sample strobes");
    chk_int(seen_drv, 4, "R6", "drive strobes after full lows");

    // R6 boundary: HOLD-1 low cycles gives none, HOLD gives one
    clear_seen();
    hold_for(0, 0, HOLD - 1); hold_for(1, 0, 40);
    chk_int(seen_drv, 0, "R6", "drive strobe after short low");
    hold_for(0, 0, HOLD); hold_for(1, 0, 40);
    chk_int(seen_drv, 1, "R6", "drive strobe after exact low");

    // stop
    clear_seen();
    hold_for(1, 1, 40);
    chk_int(seen_stop, 1, "R4", "stop after bus release");

    // R8: both lines move on the same cycle
    clear_seen();
    hold_for(0, 0, 40);
    hold_for(1, 1, 40);
    hold_for(0, 0, 40);
    hold_for(1, 1, FREE + 10);
    chk_int(seen_start + seen_stop, 0, "R8", "conditions on joint moves");

    // seeded random segments
    for (int s = 0; s < 450; s++) begin
      bit c = 1'($urandom_range(0, 1));
      bit d = 1'($urandom_range(0, 1));
      int sel = int'($urandom_range(0, 9));
      int len;
      if (sel < 3)      len = int'($urandom_range(1, SPIKE + 2));
      else if (sel < 9) len = int'($urandom_range(1, 2 * HOLD));
      else              len = int'($urandom_range(FREE - 5, FREE + 150));
      hold_for(c, d, len);
    end
    hold_for(1, 1, 60);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule